// File: doc/BRIEF.md
# Early-Tag Way Predictor and Decoder

This block sits beside a small two-way set-associative L1 data cache. When a memory instruction enters the load/store queue, its address is probed against a private copy of the cache tags. A match predicts the way that will hit, and the later cache access then enables only that way. Without a match, the access falls back to normal mode, and every way of the tag and data arrays is enabled.

Every fill of the real L1 tag array is presented on the fill port in the same cycle, so the copy stays coherent with the real array. When the real access completes, the cache reports its hit/miss result and the way that actually hit. The block combines these with the most recent prediction and reports a single outcome: hit, miss or inconsistent.

Top module: `early_way_predictor`

## Requirements
- R1: After reset, predValid, outValid, earlyHit and outcome read 0 and wayEn reads 2'b00; all entries of the copy are invalid, so the first probe of each set is an early miss.
- R2: An 8-bit address decodes as tag = bits [7:3], set index = bits [2:1] and offset = bit [0].
- R3: A probe whose tag matches a valid entry in its set gives, one cycle later, predValid=1, earlyHit=1, predWay equal to the matching way, and wayEn one-hot with bit w set for way w.
- R4: A probe with no matching valid entry gives, one cycle later, predValid=1, earlyHit=0 and wayEn=2'b11 (normal mode).
- R5: A fill writes its tag into the given set and way and marks that entry valid. A probe in the cycle after the fill sees the new entry, and a probe in the same cycle as the fill sees the old contents.
- R6: The offset bit has no effect on the prediction.
- R7: When respValid is asserted with respCacheHit=1, an early hit from the last prediction and respWay equal to its predWay, outcome becomes 2'b01 (hit) one cycle later.
- R8: When respValid is asserted with respCacheHit=0 and the last prediction was an early miss, outcome becomes 2'b10 (miss).
- R9: Any other combination gives outcome 2'b11 (inconsistent): a cache hit after an early miss, a cache hit in a way other than the predicted one, or a cache miss after an early hit.
- R10: predValid and outValid are single-cycle pulses one cycle after reqValid and respValid respectively. wayEn, earlyHit and predWay hold until the next probe, and outcome holds until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load/store queue probe strobe |
| reqAddr | input | 8 | Probe address |
| fillValid | input | 1 | L1 tag fill strobe, mirrored into the copy |
| fillAddr | input | 8 | Fill address |
| fillWay | input | 1 | Way being filled |
| respValid | input | 1 | Real cache access completed |
| respCacheHit | input | 1 | Real access hit in L1 |
| respWay | input | 1 | Way that actually hit |
| predValid | output | 1 | Prediction updated this cycle |
| wayEn | output | 2 | Way enables for the cache access |
| earlyHit | output | 1 | Prediction came from a copy hit |
| predWay | output | 1 | Predicted way |
| outValid | output | 1 | Outcome updated this cycle |
| outcome | output | 2 | 01 hit, 10 miss, 11 inconsistent |

## Verification
The copy is swept with every tag against every set, using both offset values, after the sets have been loaded with distinct tags in each way. This tells hits in way 0, hits in way 1 and misses apart, and shows that the offset bit is ignored. Before this, each set is probed empty to confirm the reset state. A fill and a probe of the same entry are issued in the same cycle to separate the old contents from the new. The decoder is driven with all three kinds of prediction (way 0, way 1, early miss), crossed with both cache results and both actual ways. This covers each path into hit, miss and inconsistent.

// File: rtl/etwp_pkg.sv
package etwp_pkg;
  typedef enum logic [1:0] {
    OUT_NONE   = 2'b00,
    OUT_HIT    = 2'b01,
    OUT_MISS   = 2'b10,
    OUT_INCONS = 2'b11
  } outcome_e;

  typedef struct packed {
    logic probe;
    logic fill;
    logic judge;
  } strobes_t;
endpackage

// File: rtl/etwp_ctrl.sv
module etwp_ctrl
  import etwp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     fillValid,
  input  logic     respValid,
  output strobes_t strobes,
  output logic     predValid,
  output logic     outValid
);
  always_comb begin
    strobes.probe = reqValid;
    strobes.fill  = fillValid;
    strobes.judge = respValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      predValid <= reqValid;
      outValid  <= respValid;
    end
  end

  p_pred_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> predValid);
  p_out_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |=> !outValid);
endmodule

// File: rtl/etwp_datapath.sv
module etwp_datapath
  import etwp_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int IDX_W = 2,
  parameter int WAYS  = 2,
  localparam int SETS  = 1 << IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [TAG_W-1:0] fillTag,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             respCacheHit,
  input  logic [WAY_W-1:0] respWay,
  output logic [WAYS-1:0]  wayEn,
  output logic             earlyHit,
  output logic [WAY_W-1:0] predWay,
  output outcome_e         outcome
);
  logic [TAG_W-1:0] tagMem   [WAYS][SETS];
  logic             validMem [WAYS][SETS];
  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] hitWay;
  logic             anyHit;
  outcome_e         verdict;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = validMem[w][reqIdx] && (tagMem[w][reqIdx] == reqTag);

    always_ff @(posedge clk) begin
      if (strobes.fill && fillWay == WAY_W'(w))
        tagMem[w][fillIdx] <= fillTag;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < SETS; s++) validMem[w][s] <= 1'b0;
      end else if (strobes.fill && fillWay == WAY_W'(w)) begin
        validMem[w][fillIdx] <= 1'b1;
      end
    end
  end

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hitWay = WAY_W'(w);
  end
  assign anyHit = |match;

  always_comb begin
    if (!respCacheHit)
      verdict = earlyHit ? OUT_INCONS : OUT_MISS;
    else if (earlyHit && predWay == respWay)
      verdict = OUT_HIT;
    else
      verdict = OUT_INCONS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wayEn    <= '0;
      earlyHit <= 1'b0;
      predWay  <= '0;
      outcome  <= OUT_NONE;
    end else begin
      if (strobes.probe) begin
        earlyHit <= anyHit;
        predWay  <= hitWay;
        wayEn    <= anyHit ? (WAYS'(1) << hitWay) : '1;
      end
      if (strobes.judge) outcome <= verdict;
    end
  end

  p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fill |=> validMem[$past(fillWay)][$past(fillIdx)]);
endmodule

// File: rtl/early_way_predictor.sv
module early_way_predictor
  import etwp_pkg::*;
#(
  parameter int TAG_W = 5,
  parameter int IDX_W = 2,
  parameter int OFS_W = 1,
  parameter int WAYS  = 2,
  localparam int ADDR_W = TAG_W + IDX_W + OFS_W,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [WAY_W-1:0]  fillWay,
  input  logic              respValid,
  input  logic              respCacheHit,
  input  logic [WAY_W-1:0]  respWay,
  output logic              predValid,
  output logic [WAYS-1:0]   wayEn,
  output logic              earlyHit,
  output logic [WAY_W-1:0]  predWay,
  output logic              outValid,
  output logic [1:0]        outcome
);
  strobes_t strobes;
  outcome_e outcomeQ;
  logic     unusedOfs;

  assign unusedOfs = ^{reqAddr[OFS_W-1:0], fillAddr[OFS_W-1:0]};
  assign outcome   = outcomeQ;

  etwp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fillValid(fillValid),
    .respValid(respValid), .strobes(strobes), .predValid(predValid),
    .outValid(outValid)
  );

  etwp_datapath #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqTag(reqAddr[ADDR_W-1 -: TAG_W]), .reqIdx(reqAddr[OFS_W +: IDX_W]),
    .fillTag(fillAddr[ADDR_W-1 -: TAG_W]), .fillIdx(fillAddr[OFS_W +: IDX_W]),
    .fillWay(fillWay), .respCacheHit(respCacheHit), .respWay(respWay),
    .wayEn(wayEn), .earlyHit(earlyHit), .predWay(predWay), .outcome(outcomeQ)
  );

  p_onehot_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && earlyHit) |-> ($countones(wayEn) == 1));
  p_all_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !earlyHit) |-> (wayEn == '1));
  p_miss_not_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respCacheHit) |=> (outcome != 2'b01));
  p_judge_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> outValid);
endmodule

// File: tb/early_way_predictor_tb.sv
`timescale 1ns/1ps
module early_way_predictor_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, fillValid = 0, respValid = 0, respCacheHit = 0;
  logic [7:0] reqAddr = 0, fillAddr = 0;
  logic fillWay = 0, respWay = 0;
  logic predValid, earlyHit, predWay, outValid;
  logic [1:0] wayEn, outcome;
  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0] mTag [4][2];
  bit mVal [4][2];

  always #4 clk = ~clk;

  early_way_predictor u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillWay(fillWay),
    .respValid(respValid), .respCacheHit(respCacheHit), .respWay(respWay),
    .predValid(predValid), .wayEn(wayEn), .earlyHit(earlyHit),
    .predWay(predWay), .outValid(outValid), .outcome(outcome)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(int tag, int idx, int way);
    @(negedge clk);
    fillValid = 1; fillAddr = 8'((tag << 3) | (idx << 1)); fillWay = 1'(way);
    @(negedge clk);
    fillValid = 0;
    mTag[idx][way] = 5'(tag); mVal[idx][way] = 1;
  endtask

  task automatic probe(int tag, int idx, int ofs);
    @(negedge clk);
    reqValid = 1; reqAddr = 8'((tag << 3) | (idx << 1) | ofs);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic expectPred(string req, int tag, int idx);
    int hw = -1;
    for (int w = 1; w >= 0; w--) if (mVal[idx][w] && mTag[idx][w] == 5'(tag)) hw = w;
    chk({req, " predValid"}, predValid, 1);
    chk({req, " earlyHit"}, earlyHit, hw >= 0);
    chk({req, " wayEn"}, wayEn, hw >= 0 ? (1 << hw) : 3);
    if (hw >= 0) chk({req, " predWay"}, predWay, hw);
  endtask

  task automatic respond(int hit, int way);
    @(negedge clk);
    respValid = 1; respCacheHit = 1'(hit); respWay = 1'(way);
    @(negedge clk);
    respValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) begin mVal[s][w] = 0; mTag[s][w] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 predValid", predValid, 0); chk("R1 outValid", outValid, 0);
    chk("R1 earlyHit", earlyHit, 0);   chk("R1 wayEn", wayEn, 0);
    chk("R1 outcome", outcome, 0);
    for (int s = 0; s < 4; s++) begin
      probe(0, s, 0);
      expectPred("R1 empty set", 0, s);
      chk("R10 predValid pulse", predValid, 1);
      @(negedge clk);
      chk("R10 predValid drops", predValid, 0);
      chk("R10 wayEn held", wayEn, 3);
    end
    // R5 load distinct tags
    for (int s = 0; s < 4; s++) begin
      if (s != 3) fill((s * 7 + 3) % 32, s, 0);
      fill((s * 5 + 17) % 32, s, 1);
    end
    // R2 R3 R4 R6 sweep all tags, sets, offsets
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 32; t++)
        for (int o = 0; o < 2; o++) begin
          probe(t, s, o);
          expectPred(o ? "R6 offset1" : "R2 R3 R4 sweep", t, s);
        end
    // R5 same-cycle fill and probe of the same entry
    @(negedge clk);
    fillValid = 1; fillAddr = 8'((5 << 3) | (3 << 1)); fillWay = 0;
    reqValid = 1;  reqAddr = fillAddr;
    @(negedge clk);
    fillValid = 0; reqValid = 0;
    chk("R5 same-cycle old contents", earlyHit, 0);
    chk("R5 same-cycle wayEn", wayEn, 3);
    mTag[3][0] = 5; mVal[3][0] = 1;
    probe(5, 3, 0);
    expectPred("R5 next-cycle visible", 5, 3);
    // R7 R8 R9 classification sweep: prediction kinds 0=way0,1=way1,2=miss
    for (int k = 0; k < 3; k++)
      for (int h = 0; h < 2; h++)
        for (int aw = 0; aw < 2; aw++) begin
          int exp;
          if (k == 0) probe(3, 0, 0);
          else if (k == 1) probe(17, 0, 0);
          else probe(31, 0, 0);
          respond(h, aw);
          if (h == 0) exp = (k == 2) ? 2 : 3;
          else exp = (k != 2 && k == aw) ? 1 : 3;
          chk(exp == 1 ? "R7 hit" : (exp == 2 ? "R8 miss" : "R9 inconsistent"), outcome, exp);
          chk("R10 outValid pulse", outValid, 1);
          @(negedge clk);
          chk("R10 outValid drops", outValid, 0);
          chk("R10 outcome held", outcome, exp);
        end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule